// File: doc/BRIEF.md
# Accumulator ALU Slice with Masked Status Flags

This block is the arithmetic and logic slice of an 8-bit accumulator machine that also has some 16-bit register-pair arithmetic. Each cycle it can take one operation: an opcode, two operands, a byte/word size select and the current flag byte. One clock later it returns the result, the new flag byte and a write-back strobe that tells the register file whether the result should be stored.

Each operation owns a fixed group of flag bits and writes only that group. Every other bit of the incoming flag byte passes through unchanged. The parity/overflow bit has two meanings. Arithmetic operations write signed overflow into it. Logic, rotate and shift operations write even parity of the result into it. Operations that add or subtract with the incoming carry work in two steps: first the carry is combined with the first operand, then the second operand is combined with that sum. The carry, half-carry and overflow outputs are the OR of the two steps.

Top module: `acc_alu`

## Requirements
- R1: Outputs are registered. An operation presented with `valid_i` high shows up on `result_o`, `flags_o` and `wb_o` one rising edge later, with `valid_o` high. With `valid_i` low, `valid_o` falls and the other outputs hold their values. After reset all outputs are zero.
- R2: Flag bit positions are: C=0, N=1 (subtract), PV=2 (parity/overflow), H=4, Z=6, S=7. No operation changes bits 3 and 5. Those two bits always equal the incoming flag bits.
- R3: Byte ADD, SUB and CP write S (result bit 7), Z, H (carry or borrow out of bit 3), PV (signed overflow), N (1 for SUB/CP, 0 for ADD) and C (carry or borrow out of bit 7).
- R4: ADC and SBC first add or subtract the incoming carry to or from operand A, and then add or subtract operand B from that value. C, H and PV are each the OR of the two steps.
- R5: CP sets the flags exactly as SUB does, and `result_o` carries the difference. CP, BIT, SCF and CCF drive `wb_o` low. All other defined opcodes drive `wb_o` high.
- R6: Byte INC and DEC update S, Z, H, PV and N like an add or subtract of 1, and keep C. Word INC and DEC return A±1 and keep the whole flag byte.
- R7: A word ADD returns the 16-bit sum. It writes C (carry out of bit 15), clears N, and keeps S, Z, PV and H.
- R8: Word ADC, SUB, SBC and CP take S from result bit 15, set Z when all 16 result bits are zero, take H from bit 11 and take PV from 16-bit signed overflow.
- R9: AND, OR and XOR work on the low bytes and return zero in the upper byte. They set PV when the result has an even number of ones, set H only for AND, and clear N and C. The size select is ignored.
- R10: RLC, RRC, RL and RR rotate (RL and RR rotate through C). SLA shifts left and fills bit 0 with 0. SRA shifts right and keeps bit 7. SRL shifts right and fills bit 7 with 0. The bit shifted out goes to C. H and N are cleared, and S, Z and PV (even parity) follow the result.
- R11: BIT returns A AND (1 << B[2:0]). It sets Z when that value is zero and S from its bit 7, sets H, clears N, and keeps C and PV.
- R12: SCF sets C and clears H and N. CCF inverts C, copies the old C into H and clears N. Both keep S, Z and PV and return a zero result.
- R13: Opcode codes: ADD 0, ADC 1, SUB 2, SBC 3, CP 4, INC 5, DEC 6, AND 7, OR 8, XOR 9, RLC 10, RRC 11, RL 12, RR 13, SLA 14, SRA 15, SRL 16, BIT 17, SCF 18, CCF 19. Codes 20 to 31 keep the flags and return a zero result with `wb_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 5 | Opcode (see R13) |
| word_i | input | 1 | 1 selects 16-bit arithmetic, 0 selects byte |
| a_i | input | 16 | First operand (the accumulator or a register pair) |
| b_i | input | 16 | Second operand, or the bit index for BIT |
| flags_i | input | 8 | Current flag byte |
| valid_o | output | 1 | Registered result is valid |
| result_o | output | 16 | Operation result |
| flags_o | output | 8 | Updated flag byte |
| wb_o | output | 1 | Result should be written back |

## Verification
The vectors go after the signed boundaries 0x7F+1, 0x80-1, 0xFF+1 and 0x00-1, where a design that mixes up carry and overflow, or that lets INC and DEC touch C, produces a wrong PV or C bit. The two-step carry cases (0x7F plus carry plus 0xFF, and 0x00 minus carry) catch a single-step adder: it would clear the overflow that the OR of the two steps keeps. Word ADD with the S, Z and PV bits preset catches a design that rewrites the full arithmetic group. Flag inputs with bits 3 and 5 set catch a merge that drops spare bits. The cases that must not write back, and the unused opcodes, are checked at `wb_o` and `flags_o`.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 16;
  localparam int BW = 8;
  localparam int FW = 8;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CP  = 5'd4,  OP_INC = 5'd5,  OP_DEC = 5'd6,  OP_AND = 5'd7,
    OP_OR  = 5'd8,  OP_XOR = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RL  = 5'd12, OP_RR  = 5'd13, OP_SLA = 5'd14, OP_SRA = 5'd15,
    OP_SRL = 5'd16, OP_BIT = 5'd17, OP_SCF = 5'd18, OP_CCF = 5'd19
  } alu_op_e;

  localparam int F_C  = 0;
  localparam int F_N  = 1;
  localparam int F_PV = 2;
  localparam int F_H  = 4;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;

  localparam logic [FW-1:0] M_SZ    = 8'hC0;
  localparam logic [FW-1:0] M_ARITH = 8'h17;
  localparam logic [FW-1:0] M_CH    = 8'h11;
  localparam logic [FW-1:0] M_CN    = 8'h03;
  localparam logic [FW-1:0] M_SCCF  = 8'h13;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          h;
    logic          v;
  } step_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic          word_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output step_t         out_o,
  output logic          sub_o
);
  localparam int HB_W = 12;  // half-carry boundary, word
  localparam int HB_B = 4;   // half-carry boundary, byte

  function automatic step_t step(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                 input logic sub, input logic word);
    step_t       r;
    logic [DW:0] sw;
    logic [BW:0] sb;
    if (word) begin
      sw    = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
      r.res = sw[DW-1:0];
      r.c   = sw[DW];
      r.h   = x[HB_W] ^ y[HB_W] ^ sw[HB_W];
      r.v   = (sub ? (x[DW-1] ^ y[DW-1]) : ~(x[DW-1] ^ y[DW-1])) & (x[DW-1] ^ sw[DW-1]);
    end else begin
      sb    = sub ? ({1'b0, x[BW-1:0]} - {1'b0, y[BW-1:0]})
                  : ({1'b0, x[BW-1:0]} + {1'b0, y[BW-1:0]});
      r.res = {{(DW-BW){1'b0}}, sb[BW-1:0]};
      r.c   = sb[BW];
      r.h   = x[HB_B] ^ y[HB_B] ^ sb[HB_B];
      r.v   = (sub ? (x[BW-1] ^ y[BW-1]) : ~(x[BW-1] ^ y[BW-1])) & (x[BW-1] ^ sb[BW-1]);
    end
    return r;
  endfunction

  logic          use_cin;
  logic [DW-1:0] opnd;
  step_t         s1, s2;

  always_comb begin
    sub_o   = op_i inside {OP_SUB, OP_SBC, OP_CP, OP_DEC};
    use_cin = op_i inside {OP_ADC, OP_SBC};
    opnd    = (op_i inside {OP_INC, OP_DEC}) ? {{(DW-1){1'b0}}, 1'b1} : b_i;
    // carry first, then second operand
    s1      = step(a_i, {{(DW-1){1'b0}}, use_cin & cin_i}, sub_o, word_i);
    s2      = step(s1.res, opnd, sub_o, word_i);
    out_o.res = s2.res;
    out_o.c   = s1.c | s2.c;
    out_o.h   = s1.h | s2.h;
    out_o.v   = s1.v | s2.v;
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic [BW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  input  logic          cin_i,
  output logic [BW-1:0] res_o,
  output logic          out_c_o
);
  always_comb begin
    res_o   = '0;
    out_c_o = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_RLC: begin res_o = {a_i[BW-2:0], a_i[BW-1]}; out_c_o = a_i[BW-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[BW-1:1]};    out_c_o = a_i[0];    end
      OP_RL:  begin res_o = {a_i[BW-2:0], cin_i};     out_c_o = a_i[BW-1]; end
      OP_RR:  begin res_o = {cin_i, a_i[BW-1:1]};     out_c_o = a_i[0];    end
      OP_SLA: begin res_o = {a_i[BW-2:0], 1'b0};      out_c_o = a_i[BW-1]; end
      OP_SRA: begin res_o = {a_i[BW-1], a_i[BW-1:1]}; out_c_o = a_i[0];    end
      OP_SRL: begin res_o = {1'b0, a_i[BW-1:1]};      out_c_o = a_i[0];    end
      OP_BIT: res_o = a_i & (BW'(1) << b_i[2:0]);
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_flag_gen.sv
module acc_alu_flag_gen
  import acc_alu_pkg::*;
(
  input  alu_op_e       op_i,
  input  logic          word_i,
  input  step_t         ar_i,
  input  logic          sub_i,
  input  logic [BW-1:0] br_i,
  input  logic          bc_i,
  input  logic [FW-1:0] flags_i,
  output logic [DW-1:0] res_o,
  output logic [FW-1:0] flags_o,
  output logic          wb_o
);
  logic [FW-1:0] mask, val;
  logic          sgn, zer;

  always_comb begin
    mask  = '0;
    val   = '0;
    res_o = '0;
    wb_o  = 1'b0;
    sgn   = 1'b0;
    zer   = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_INC, OP_DEC: begin
        res_o = ar_i.res;
        wb_o  = (op_i != OP_CP);
        sgn   = word_i ? ar_i.res[DW-1] : ar_i.res[BW-1];
        zer   = (ar_i.res == '0);
        if (word_i && op_i == OP_ADD) begin
          mask = M_CN;
        end else if (word_i && op_i inside {OP_INC, OP_DEC}) begin
          mask = '0;
        end else if (op_i inside {OP_INC, OP_DEC}) begin
          mask = (M_SZ | M_ARITH) & ~FW'(1 << F_C);
        end else begin
          mask = M_SZ | M_ARITH;
        end
        val[F_S]  = sgn;
        val[F_Z]  = zer;
        val[F_H]  = ar_i.h;
        val[F_PV] = ar_i.v;
        val[F_N]  = sub_i;
        val[F_C]  = ar_i.c;
      end
      OP_AND, OP_OR, OP_XOR, OP_RLC, OP_RRC, OP_RL, OP_RR,
      OP_SLA, OP_SRA, OP_SRL: begin
        res_o     = {{(DW-BW){1'b0}}, br_i};
        wb_o      = 1'b1;
        mask      = M_SZ | M_ARITH;
        val[F_S]  = br_i[BW-1];
        val[F_Z]  = (br_i == '0);
        val[F_PV] = ~^br_i;
        val[F_H]  = (op_i == OP_AND);
        val[F_C]  = (op_i inside {OP_AND, OP_OR, OP_XOR}) ? 1'b0 : bc_i;
      end
      OP_BIT: begin
        res_o    = {{(DW-BW){1'b0}}, br_i};
        mask     = M_SZ | FW'(1 << F_H) | FW'(1 << F_N);
        val[F_S] = br_i[BW-1];
        val[F_Z] = (br_i == '0);
        val[F_H] = 1'b1;
      end
      OP_SCF: begin
        mask     = M_SCCF;
        val[F_C] = 1'b1;
      end
      OP_CCF: begin
        mask     = M_SCCF;
        val[F_H] = flags_i[F_C];
        val[F_C] = ~flags_i[F_C];
      end
      default: ;
    endcase
    flags_o = (flags_i & ~mask) | (val & mask);
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [4:0]    op_i,
  input  logic          word_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [FW-1:0] flags_i,
  output logic          valid_o,
  output logic [DW-1:0] result_o,
  output logic [FW-1:0] flags_o,
  output logic          wb_o
);
  alu_op_e       op;
  step_t         ar;
  logic          sub;
  logic [BW-1:0] br;
  logic          bc;
  logic [DW-1:0] res_d;
  logic [FW-1:0] flags_d;
  logic          wb_d;

  assign op = alu_op_e'(op_i);

  acc_alu_arith u_arith (
    .op_i(op), .word_i(word_i), .a_i(a_i), .b_i(b_i),
    .cin_i(flags_i[F_C]), .out_o(ar), .sub_o(sub)
  );

  acc_alu_bitops u_bitops (
    .op_i(op), .a_i(a_i[BW-1:0]), .b_i(b_i[BW-1:0]),
    .cin_i(flags_i[F_C]), .res_o(br), .out_c_o(bc)
  );

  acc_alu_flag_gen u_flags (
    .op_i(op), .word_i(word_i), .ar_i(ar), .sub_i(sub), .br_i(br),
    .bc_i(bc), .flags_i(flags_i), .res_o(res_d), .flags_o(flags_d), .wb_o(wb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
      wb_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flags_d;
        wb_o     <= wb_d;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flags_o) && $stable(wb_o) && !valid_o);

  a_r2_spare_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[3] == $past(flags_i[3]) && flags_o[5] == $past(flags_i[5]));

  a_r5_no_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {5'd4, 5'd17, 5'd18, 5'd19}) |=> !wb_o);

  a_r6_incdec_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !word_i && (op_i inside {5'd5, 5'd6}) |=> flags_o[F_C] == $past(flags_i[F_C]));

  a_r7_word_add_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && word_i && op_i == 5'd0 |=> flags_o[7:2] == $past(flags_i[7:2]) && !flags_o[F_N]);

  a_r12_scf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 5'd18 |=> flags_o[F_C] && !flags_o[F_N] && !flags_o[F_H]);
endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  op = '0;
  logic        word = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [7:0]  fin = '0;
  logic        valid_o, wb_o;
  logic [15:0] result_o;
  logic [7:0]  flags_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .word_i(word),
    .a_i(a), .b_i(b), .flags_i(fin), .valid_o(valid_o), .result_o(result_o),
    .flags_o(flags_o), .wb_o(wb_o)
  );

  // {req, op, word, a, b, flags_in, exp_result, exp_flags, exp_wb}
  localparam int NV = 31;
  localparam logic [74:0] VECS [NV] = '{
    {4'd3,  5'd0,  1'b0, 16'h007F, 16'h0001, 8'h00, 16'h0080, 8'h94, 1'b1}, // R3 add 7F+1
    {4'd3,  5'd2,  1'b0, 16'h0000, 16'h0001, 8'h00, 16'h00FF, 8'h93, 1'b1}, // R3 sub 00-1
    {4'd5,  5'd4,  1'b0, 16'h0080, 16'h0001, 8'h28, 16'h007F, 8'h3E, 1'b0}, // R5 cp 80-1
    {4'd4,  5'd1,  1'b0, 16'h007F, 16'h00FF, 8'h01, 16'h007F, 8'h15, 1'b1}, // R4 adc two-step
    {4'd4,  5'd3,  1'b0, 16'h0000, 16'h0000, 8'h01, 16'h00FF, 8'h93, 1'b1}, // R4 sbc
    {4'd7,  5'd0,  1'b1, 16'hFFFF, 16'h0001, 8'hE4, 16'h0000, 8'hE5, 1'b1}, // R7 word add
    {4'd8,  5'd1,  1'b1, 16'h7FFF, 16'h0000, 8'h01, 16'h8000, 8'h94, 1'b1}, // R8 word adc
    {4'd8,  5'd3,  1'b1, 16'h1000, 16'h0000, 8'h01, 16'h0FFF, 8'h12, 1'b1}, // R8 word sbc
    {4'd8,  5'd2,  1'b1, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h93, 1'b1}, // R8 word sub
    {4'd9,  5'd7,  1'b0, 16'h00F0, 16'h003C, 8'h01, 16'h0030, 8'h14, 1'b1}, // R9 and
    {4'd9,  5'd9,  1'b0, 16'h00AA, 16'h00AA, 8'hFF, 16'h0000, 8'h6C, 1'b1}, // R9 xor
    {4'd9,  5'd8,  1'b1, 16'hFF01, 16'h0002, 8'h00, 16'h0003, 8'h04, 1'b1}, // R9 or, size ignored
    {4'd10, 5'd10, 1'b0, 16'h0081, 16'h0000, 8'h00, 16'h0003, 8'h05, 1'b1}, // R10 rlc
    {4'd10, 5'd13, 1'b0, 16'h0001, 16'h0000, 8'h00, 16'h0000, 8'h45, 1'b1}, // R10 rr
    {4'd10, 5'd12, 1'b0, 16'h0080, 16'h0000, 8'h01, 16'h0001, 8'h01, 1'b1}, // R10 rl
    {4'd10, 5'd15, 1'b0, 16'h0081, 16'h0000, 8'h00, 16'h00C0, 8'h85, 1'b1}, // R10 sra
    {4'd10, 5'd16, 1'b0, 16'h0081, 16'h0000, 8'h00, 16'h0040, 8'h01, 1'b1}, // R10 srl
    {4'd10, 5'd14, 1'b0, 16'h00C0, 16'h0000, 8'h00, 16'h0080, 8'h81, 1'b1}, // R10 sla
    {4'd10, 5'd11, 1'b0, 16'h0001, 16'h0000, 8'h00, 16'h0080, 8'h81, 1'b1}, // R10 rrc
    {4'd11, 5'd17, 1'b0, 16'h0080, 16'h0007, 8'h05, 16'h0080, 8'h95, 1'b0}, // R11 bit 7 set
    {4'd11, 5'd17, 1'b0, 16'h00FE, 16'h0000, 8'h00, 16'h0000, 8'h50, 1'b0}, // R11 bit 0 clear
    {4'd12, 5'd18, 1'b0, 16'h0000, 16'h0000, 8'hD6, 16'h0000, 8'hC5, 1'b0}, // R12 scf
    {4'd12, 5'd19, 1'b0, 16'h0000, 16'h0000, 8'h03, 16'h0000, 8'h10, 1'b0}, // R12 ccf 1->0
    {4'd12, 5'd19, 1'b0, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h01, 1'b0}, // R12 ccf 0->1
    {4'd6,  5'd5,  1'b0, 16'h00FF, 16'h0000, 8'h01, 16'h0000, 8'h51, 1'b1}, // R6 inc FF
    {4'd6,  5'd5,  1'b0, 16'h007F, 16'h0000, 8'h00, 16'h0080, 8'h94, 1'b1}, // R6 inc 7F
    {4'd6,  5'd6,  1'b0, 16'h0080, 16'h0000, 8'h00, 16'h007F, 8'h16, 1'b1}, // R6 dec 80
    {4'd6,  5'd6,  1'b0, 16'h0000, 16'h0000, 8'h01, 16'h00FF, 8'h93, 1'b1}, // R6 dec 00
    {4'd6,  5'd5,  1'b1, 16'hFFFF, 16'h0000, 8'h5A, 16'h0000, 8'h5A, 1'b1}, // R6 word inc
    {4'd6,  5'd6,  1'b1, 16'h0000, 16'h0000, 8'hA5, 16'hFFFF, 8'hA5, 1'b1}, // R6 word dec
    {4'd13, 5'd25, 1'b0, 16'h1234, 16'h5678, 8'hA5, 16'h0000, 8'hA5, 1'b0}  // R13 unused code
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] o, input logic w, input logic [15:0] x,
                       input logic [15:0] y, input logic [7:0] f);
    @(negedge clk);
    valid = 1'b1; op = o; word = w; a = x; b = y; fin = f;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {valid_o, wb_o, flags_o, result_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VECS[i];
      issue(v[70:66], v[65], v[64:49], v[48:33], v[32:25]);
      check($sformatf("R%0d vec %0d", v[74:71], i),
            {6'd0, valid_o, wb_o, flags_o, result_o}, {6'd0, 1'b1, v[0], v[8:1], v[24:9]});
    end

    // R1 hold while idle
    issue(5'd0, 1'b0, 16'h0011, 16'h0022, 8'h00);
    check("R1 issued", {8'd0, flags_o, result_o}, {8'd0, 8'h00, 16'h0033});
    @(negedge clk);
    valid = 1'b0; op = 5'd2; a = 16'h00FF; fin = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    check("R1 idle hold", {7'd0, valid_o, flags_o, result_o}, {7'd0, 1'b0, 8'h00, 16'h0033});

    // R2 spare bits pass through on an arithmetic op
    issue(5'd0, 1'b0, 16'h0001, 16'h0001, 8'h28);
    check("R2 spare bits", {24'd0, flags_o}, {24'd0, 8'h28});

    // R5 cp and sub agree on flags
    issue(5'd2, 1'b0, 16'h0040, 16'h0050, 8'h00);
    begin
      logic [7:0] sub_fl;
      sub_fl = flags_o;
      issue(5'd4, 1'b0, 16'h0040, 16'h0050, 8'h00);
      check("R5 cp equals sub", {24'd0, flags_o}, {24'd0, sub_fl});
      check("R5 sub flags", {24'd0, sub_fl}, {24'd0, 8'h83});
    end

    @(negedge clk);
    valid = 1'b0;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule